// File: doc/BRIEF.md
# Broadcast-Coded Periodic Sequence Level Generator

This block runs in programmable logic on the system clock (40 MHz in the target system) and turns two broadcast commands into two long-lived sequence levels. It watches an 8-bit broadcast bus together with two qualifying strobes. When the bus carries the sequence-reset code under its strobe, it drives the sequence-reset level. When the bus carries the sequence-test code under the other strobe, it drives the sequence-test level.

A decoded command does not give a single pulse. While the command stays on the bus, its output is held high for a long window of about 3 µs (120 clocks at 40 MHz). It then drops for a short gap of one or two clocks and rises again. This pattern repeats for as long as the command is held. Anything sampling the level should therefore expect it to read low now and then, even while the command is present.

Both channels are registered. Each has its own window counter, and the window length, gap length, codes and bus width are all parameters.

Top module: `seq_pulse_gen`

## Requirements
- R1: While the synchronous reset is high, both outputs are low in the following cycle. After reset is released with a command already held, that command's output starts a fresh full window.
- R2: The reset channel qualifies only when `stb_rst_i` is 1 and the bus equals `RST_CODE` (default 0x08). Any other bus value, or the test strobe alone, leaves `seq_rst_o` low.
- R3: The test channel qualifies only when `stb_tst_i` is 1 and the bus equals `TST_CODE` (default 0x80). Any other bus value, or the reset strobe alone, leaves `seq_tst_o` low.
- R4: The clock edge that first samples a qualified command raises that channel's output. The output stays high for exactly `HIGH_LEN` cycles (default 120).
- R5: After each high window, the output is low for exactly `GAP_LEN` cycles (default 2) and then reasserts. The high/gap period repeats without drift while the command stays qualified.
- R6: When a channel stops being qualified (its code or its strobe goes away), its output is low from the next cycle. A later qualification starts a fresh full window.
- R7: The two channels are independent, and at most one output is high in any cycle. Switching the bus from one command to the other starts the new channel with a full window.
- R8: If both channels qualify in the same cycle (possible only when the two code parameters are equal), the reset channel wins. The test output stays low and its window counter stays cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bcast_i | input | BUS_W (8) | Broadcast command bus |
| stb_rst_i | input | 1 | Qualifying strobe for the sequence-reset command |
| stb_tst_i | input | 1 | Qualifying strobe for the sequence-test command |
| seq_rst_o | output | 1 | Sequence-reset level, periodically gapped |
| seq_tst_o | output | 1 | Sequence-test level, periodically gapped |

## Verification
The assertions check the following on every cycle:
- An output is high only one cycle after its own command was qualified.
- An output drops the cycle after its command is lost.
- A newly qualified command raises its output at once.
- No run of high cycles exceeds the window length.
- The two levels are never high together.
- The priority rule holds.

The bench's scenarios show the parts that only long runs can reveal:
- the exact gap length and the reassertion after it;
- the absence of drift over several periods;
- the fresh window after a drop, a reset or a change of command;
- the full sweep of bus values and strobe combinations.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_RST = 0;
  localparam int CH_TST = 1;

  function automatic int cnt_width(input int period);
    return (period <= 2) ? 1 : $clog2(period);
  endfunction
endpackage

// File: rtl/seq_decode.sv
module seq_decode #(
  parameter int BUS_W = 8,
  parameter logic [BUS_W-1:0] RST_CODE = 8'h08,
  parameter logic [BUS_W-1:0] TST_CODE = 8'h80
) (
  input  logic [BUS_W-1:0]             bcast_i,
  input  logic                         stb_rst_i,
  input  logic                         stb_tst_i,
  output logic [seqgen_pkg::NUM_CH-1:0] hit_o
);
  logic rst_match;
  logic tst_match;

  always_comb begin
    rst_match = stb_rst_i && (bcast_i == RST_CODE);
    tst_match = stb_tst_i && (bcast_i == TST_CODE);
    hit_o = '0;
    hit_o[seqgen_pkg::CH_RST] = rst_match;
    // reset command has priority when both qualify together
    hit_o[seqgen_pkg::CH_TST] = tst_match && !rst_match;
  end
endmodule

// File: rtl/seq_window.sv
module seq_window #(
  parameter int HIGH_LEN = 120,
  parameter int GAP_LEN  = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hit_i,
  output logic level_o
);
  localparam int PERIOD = HIGH_LEN + GAP_LEN;
  localparam int CW     = seqgen_pkg::cnt_width(PERIOD);
  localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HIGHS = CW'(HIGH_LEN);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !hit_i) begin
      phase_q <= '0;
      level_o <= 1'b0;
    end else begin
      level_o <= (phase_q < HIGHS);
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/seq_pulse_gen.sv
module seq_pulse_gen #(
  parameter int BUS_W    = 8,
  parameter int HIGH_LEN = 120,
  parameter int GAP_LEN  = 2,
  parameter logic [BUS_W-1:0] RST_CODE = 8'h08,
  parameter logic [BUS_W-1:0] TST_CODE = 8'h80
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [BUS_W-1:0] bcast_i,
  input  logic             stb_rst_i,
  input  logic             stb_tst_i,
  output logic             seq_rst_o,
  output logic             seq_tst_o
);
  logic [seqgen_pkg::NUM_CH-1:0] hit;
  logic [seqgen_pkg::NUM_CH-1:0] level;

  seq_decode #(
    .BUS_W(BUS_W), .RST_CODE(RST_CODE), .TST_CODE(TST_CODE)
  ) u_decode (
    .bcast_i(bcast_i), .stb_rst_i(stb_rst_i), .stb_tst_i(stb_tst_i), .hit_o(hit)
  );

  for (genvar ch = 0; ch < seqgen_pkg::NUM_CH; ch++) begin : g_ch
    seq_window #(.HIGH_LEN(HIGH_LEN), .GAP_LEN(GAP_LEN)) u_win (
      .clk_i(clk_i), .rst_i(rst_i), .hit_i(hit[ch]), .level_o(level[ch])
    );
  end

  assign seq_rst_o = level[seqgen_pkg::CH_RST];
  assign seq_tst_o = level[seqgen_pkg::CH_TST];
endmodule

// File: rtl/seq_pulse_gen_chk.sv
module seq_pulse_gen_chk #(
  parameter int BUS_W    = 8,
  parameter int HIGH_LEN = 120,
  parameter int GAP_LEN  = 2,
  parameter logic [BUS_W-1:0] RST_CODE = 8'h08,
  parameter logic [BUS_W-1:0] TST_CODE = 8'h80
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [BUS_W-1:0] bcast_i,
  input logic             stb_rst_i,
  input logic             stb_tst_i,
  input logic             seq_rst_o,
  input logic             seq_tst_o
);
  logic q_rst, q_tst_raw;
  logic [15:0] run_rst, run_tst;

  assign q_rst     = stb_rst_i && (bcast_i == RST_CODE);
  assign q_tst_raw = stb_tst_i && (bcast_i == TST_CODE);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_rst <= '0;
      run_tst <= '0;
    end else begin
      run_rst <= seq_rst_o ? ((run_rst == 16'hFFFF) ? run_rst : run_rst + 1'b1) : '0;
      run_tst <= seq_tst_o ? ((run_tst == 16'hFFFF) ? run_tst : run_tst + 1'b1) : '0;
    end
  end

  a_r2_rst_needs_code: assert property (@(posedge clk_i) disable iff (rst_i)
    seq_rst_o |-> $past(q_rst));
  a_r3_tst_needs_code: assert property (@(posedge clk_i) disable iff (rst_i)
    seq_tst_o |-> $past(q_tst_raw));
  a_r4_rst_starts: assert property (@(posedge clk_i) disable iff (rst_i)
    (q_rst && !$past(q_rst)) |=> seq_rst_o);
  a_r5_rst_run_limit: assert property (@(posedge clk_i) disable iff (rst_i)
    seq_rst_o |-> (run_rst < 16'(HIGH_LEN)));
  a_r5_tst_run_limit: assert property (@(posedge clk_i) disable iff (rst_i)
    seq_tst_o |-> (run_tst < 16'(HIGH_LEN)));
  a_r6_rst_drop: assert property (@(posedge clk_i) disable iff (rst_i)
    !q_rst |=> !seq_rst_o);
  a_r6_tst_drop: assert property (@(posedge clk_i) disable iff (rst_i)
    !q_tst_raw |=> !seq_tst_o);
  a_r7_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({seq_rst_o, seq_tst_o}));
  a_r8_priority: assert property (@(posedge clk_i) disable iff (rst_i)
    (q_rst && q_tst_raw) |=> !seq_tst_o);
endmodule

bind seq_pulse_gen seq_pulse_gen_chk #(
  .BUS_W(BUS_W), .HIGH_LEN(HIGH_LEN), .GAP_LEN(GAP_LEN),
  .RST_CODE(RST_CODE), .TST_CODE(TST_CODE)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .bcast_i(bcast_i), .stb_rst_i(stb_rst_i),
  .stb_tst_i(stb_tst_i), .seq_rst_o(seq_rst_o), .seq_tst_o(seq_tst_o)
);

// File: tb/test_seq_pulse_gen.sv
`timescale 1ns/1ps
module test_seq_pulse_gen;
  localparam int H1 = 120, G1 = 2, P1 = H1 + G1;
  localparam int H2 = 5,   G2 = 1, P2 = H2 + G2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic [7:0] bus = 8'h00;
  logic       sa = 1'b0, sb = 1'b0;
  logic       o1r, o1t, o2r, o2t;
  int errors = 0, checks = 0;
  int n1r = 0, n1t = 0, n2r = 0, n2t = 0;

  seq_pulse_gen i_seq_pulse_gen (
    .clk_i(clk), .rst_i(rst), .bcast_i(bus), .stb_rst_i(sa), .stb_tst_i(sb),
    .seq_rst_o(o1r), .seq_tst_o(o1t));

  // small configuration with equal codes to exercise the priority rule
  seq_pulse_gen #(.HIGH_LEN(H2), .GAP_LEN(G2), .RST_CODE(8'h08), .TST_CODE(8'h08)) i_seq_pulse_gen_eq (
    .clk_i(clk), .rst_i(rst), .bcast_i(bus), .stb_rst_i(sa), .stb_tst_i(sb),
    .seq_rst_o(o2r), .seq_tst_o(o2t));

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, what, $time, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [7:0] b, input logic a, input logic s, input string tag);
    logic q1r, q1t, q2r, q2t, e1r, e1t, e2r, e2t;
    rst = r; bus = b; sa = a; sb = s;
    @(posedge clk);
    q1r = !r && a && (b == 8'h08);
    q1t = !r && s && (b == 8'h80);
    q2r = !r && a && (b == 8'h08);
    q2t = !r && s && (b == 8'h08) && !q2r;
    e1r = q1r && ((n1r % P1) < H1);
    e1t = q1t && ((n1t % P1) < H1);
    e2r = q2r && ((n2r % P2) < H2);
    e2t = q2t && ((n2t % P2) < H2);
    n1r = q1r ? n1r + 1 : 0;
    n1t = q1t ? n1t + 1 : 0;
    n2r = q2r ? n2r + 1 : 0;
    n2t = q2t ? n2t + 1 : 0;
    @(negedge clk);
    chk(tag, "seq_rst", o1r, e1r);
    chk(tag, "seq_tst", o1t, e1t);
    chk(tag, "eq.seq_rst", o2r, e2r);
    chk(tag, "eq.seq_tst", o2t, e2t);
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 8'h08, 1'b1, 1'b0, "R1");
    for (int i = 0; i < 2; i++) step(1'b0, 8'h00, 1'b0, 1'b0, "R1");
    // R2 / R3: sweep all bus values and strobe combinations
    for (int v = 0; v < 256; v++)
      for (int s = 0; s < 4; s++)
        step(1'b0, 8'(v), s[0], s[1], s[0] ? "R2" : "R3");
    step(1'b0, 8'h00, 1'b0, 1'b0, "R2");
    // R4 / R5: held reset command over several periods
    for (int i = 0; i < 4 * P1 + 10; i++) step(1'b0, 8'h08, 1'b1, 1'b0, "R5");
    step(1'b0, 8'h00, 1'b0, 1'b0, "R6");
    // R4: held test command, first window
    for (int i = 0; i < P1 + 5; i++) step(1'b0, 8'h80, 1'b0, 1'b1, "R4");
    // R6: strobe lost mid-window, then requalified
    step(1'b0, 8'h80, 1'b0, 1'b0, "R6");
    step(1'b0, 8'h80, 1'b0, 1'b0, "R6");
    for (int i = 0; i < P1 + 5; i++) step(1'b0, 8'h80, 1'b0, 1'b1, "R6");
    // R6: code lost mid-window with strobe held
    for (int i = 0; i < 40; i++) step(1'b0, 8'h08, 1'b1, 1'b0, "R6");
    step(1'b0, 8'h09, 1'b1, 1'b0, "R6");
    for (int i = 0; i < P1 + 3; i++) step(1'b0, 8'h08, 1'b1, 1'b0, "R6");
    // R7: switch directly from reset command to test command
    for (int i = 0; i < 30; i++) step(1'b0, 8'h08, 1'b1, 1'b0, "R7");
    for (int i = 0; i < P1 + 5; i++) step(1'b0, 8'h80, 1'b0, 1'b1, "R7");
    for (int i = 0; i < 10; i++) step(1'b0, 8'h08, 1'b1, 1'b0, "R7");
    // R1: reset during a held command, then fresh window
    for (int i = 0; i < 50; i++) step(1'b0, 8'h80, 1'b0, 1'b1, "R1");
    step(1'b1, 8'h80, 1'b0, 1'b1, "R1");
    for (int i = 0; i < P1 + 3; i++) step(1'b0, 8'h80, 1'b0, 1'b1, "R1");
    // R8: both channels qualify together in the equal-code instance
    for (int i = 0; i < 20; i++) step(1'b0, 8'h08, 1'b1, 1'b1, "R8");
    for (int i = 0; i < 15; i++) step(1'b0, 8'h08, 1'b0, 1'b1, "R8");
    for (int i = 0; i < 8; i++) step(1'b0, 8'h08, 1'b1, 1'b1, "R8");
    step(1'b0, 8'h00, 1'b0, 1'b0, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule